// File: doc/BRIEF.md
# Registered Small Complex Multiplier

This block multiplies two complex numbers whose four parts are 4-bit unsigned values. The first number is (a + jb) and the second is (c + jd). It returns an 8-bit real part, ac − bd, and an 8-bit imaginary part, ad + bc. Each part has its own overflow flag.

Inside, four array multipliers form the partial products ac, bd, ad and bc. One ripple adder sums ad and bc. A second instance of the same ripple adder forms ac − bd: it inverts every bit of bd and forces its carry-in high. Each flag is the raw carry-out of its own adder.

A register bank captures all operands on every clock edge. A second register bank holds both results and both flags, so the outputs do not glitch. There is no handshake, and a new operand set can be presented on every cycle. The block has no state machine: its only sequencing is the fixed two-stage pipeline, which is either cleared by reset or running.

Top module: `cplx_mul4_reg`

## Requirements
- R1: The operands a = `op_re_a`, b = `op_im_a`, c = `op_re_b` and d = `op_im_b` are 4-bit unsigned values. An operand set present at clock edge k gives its result on the outputs right after edge k+1. A new set is accepted on every edge, and consecutive sets do not affect each other.
- R2: `re_out` equals (a·c − b·d) modulo 256.
- R3: `im_out` equals (a·d + b·c) modulo 256.
- R4: `im_ovf` is 1 exactly when a·d + b·c > 255. It is 0 when the sum is exactly 255.
- R5: `re_ovf` is the carry-out of a·c + (bd inverted bitwise) + 1. It is therefore 1 when a·c ≥ b·d, including all-zero operands, and 0 when a·c < b·d.
- R6: `rst` is synchronous and active high. It clears both register banks. While it is held, all four outputs read 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_re_a | input | 4 | Operand a, real part of the first number |
| op_im_a | input | 4 | Operand b, imaginary part of the first number |
| op_re_b | input | 4 | Operand c, real part of the second number |
| op_im_b | input | 4 | Operand d, imaginary part of the second number |
| re_out | output | 8 | Real result, ac − bd modulo 256 |
| im_out | output | 8 | Imaginary result, ad + bc modulo 256 |
| re_ovf | output | 1 | Carry-out of the real subtraction |
| im_ovf | output | 1 | Carry-out of the imaginary addition |

## Verification
All four results of an operand set become visible together, two rising edges after the set is driven. The bench drives a new set at every falling edge and compares the outputs two falling edges later against the set driven then. Both checks fall mid-cycle, so they count exactly the input capture edge and the output register edge.

The assertions look two cycles back from the output ports to the operand ports. They are enabled only once two edges have passed since reset.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // Default operand width; results are twice as wide.
    localparam int unsigned OP_W_DEF = 4;

    // Selects how the ripple adder treats its second operand.
    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } add_mode_e;

endpackage

// File: rtl/cmul_pipe_reg.sv
module cmul_pipe_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/cmul_umul.sv
module cmul_umul #(
    parameter int unsigned OP_W = 4
) (
    input  logic [OP_W-1:0]   x,
    input  logic [OP_W-1:0]   y,
    output logic [2*OP_W-1:0] p
);

    localparam int unsigned PW = 2 * OP_W;

    // Running sums of the shifted, gated partial-product rows.
    logic [PW-1:0] acc [OP_W+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < OP_W; i++) begin : g_row
        logic [PW-1:0] row;
        assign row        = y[i] ? (PW'(x) << i) : '0;
        assign acc[i + 1] = acc[i] + row;
    end

    assign p = acc[OP_W];

endmodule

// File: rtl/cmul_ripple_add.sv
module cmul_ripple_add #(
    parameter int unsigned        W    = 8,
    parameter cmul_pkg::add_mode_e MODE = cmul_pkg::MODE_ADD
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] y_eff;
    logic [W:0]   carry;

    if (MODE == cmul_pkg::MODE_SUB) begin : g_sub
        assign y_eff    = ~y;
        assign carry[0] = 1'b1;
    end else begin : g_add
        assign y_eff    = y;
        assign carry[0] = 1'b0;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]       = x[i] ^ y_eff[i] ^ carry[i];
        assign carry[i + 1] = (x[i] & y_eff[i]) | (x[i] & carry[i]) | (y_eff[i] & carry[i]);
    end

    assign cout = carry[W];

endmodule

// File: rtl/cplx_mul4_reg.sv
module cplx_mul4_reg #(
    parameter int unsigned OP_W = cmul_pkg::OP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_re_a,
    input  logic [OP_W-1:0]   op_im_a,
    input  logic [OP_W-1:0]   op_re_b,
    input  logic [OP_W-1:0]   op_im_b,
    output logic [2*OP_W-1:0] re_out,
    output logic [2*OP_W-1:0] im_out,
    output logic              re_ovf,
    output logic              im_ovf
);

    localparam int unsigned RW    = 2 * OP_W;
    localparam int unsigned IN_W  = 4 * OP_W;
    localparam int unsigned OUT_W = 2 * RW + 2;
    localparam int unsigned SW    = RW + 1;

    // Stage 1: capture all operands.
    logic [IN_W-1:0] in_q;
    logic [OP_W-1:0] a_q, b_q, c_q, d_q;

    cmul_pipe_reg #(.W(IN_W)) u_in_reg (
        .clk (clk),
        .rst (rst),
        .d   ({op_re_a, op_im_a, op_re_b, op_im_b}),
        .q   (in_q)
    );

    assign {a_q, b_q, c_q, d_q} = in_q;

    // Four partial products.
    logic [RW-1:0] p_ac, p_bd, p_ad, p_bc;

    cmul_umul #(.OP_W(OP_W)) u_mul_ac (.x(a_q), .y(c_q), .p(p_ac));
    cmul_umul #(.OP_W(OP_W)) u_mul_bd (.x(b_q), .y(d_q), .p(p_bd));
    cmul_umul #(.OP_W(OP_W)) u_mul_ad (.x(a_q), .y(d_q), .p(p_ad));
    cmul_umul #(.OP_W(OP_W)) u_mul_bc (.x(b_q), .y(c_q), .p(p_bc));

    // Real path: subtract; imaginary path: add.
    logic [RW-1:0] re_sum, im_sum;
    logic          re_cy, im_cy;

    cmul_ripple_add #(.W(RW), .MODE(cmul_pkg::MODE_SUB)) u_re_sub (
        .x    (p_ac),
        .y    (p_bd),
        .sum  (re_sum),
        .cout (re_cy)
    );

    cmul_ripple_add #(.W(RW), .MODE(cmul_pkg::MODE_ADD)) u_im_add (
        .x    (p_ad),
        .y    (p_bc),
        .sum  (im_sum),
        .cout (im_cy)
    );

    // Stage 2: register results and flags.
    logic [OUT_W-1:0] out_q;

    cmul_pipe_reg #(.W(OUT_W)) u_out_reg (
        .clk (clk),
        .rst (rst),
        .d   ({re_sum, im_sum, re_cy, im_cy}),
        .q   (out_q)
    );

    assign {re_out, im_out, re_ovf, im_ovf} = out_q;

    // Cycles since reset release, saturating at 2; gates lookback checks.
    logic [1:0] warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (re_out == '0 && im_out == '0 && !re_ovf && !im_ovf)); // R6

    AST_RE_DIFF: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |->
        re_out == RW'(SW'($past(op_re_a, 2)) * SW'($past(op_re_b, 2))
                    - SW'($past(op_im_a, 2)) * SW'($past(op_im_b, 2)))); // R2

    AST_IM_SUM: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |->
        im_out == RW'(SW'($past(op_re_a, 2)) * SW'($past(op_im_b, 2))
                    + SW'($past(op_im_a, 2)) * SW'($past(op_re_b, 2)))); // R3

    AST_IM_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |->
        im_ovf == ((SW'($past(op_re_a, 2)) * SW'($past(op_im_b, 2))
                  + SW'($past(op_im_a, 2)) * SW'($past(op_re_b, 2))) > SW'((1 << RW) - 1))); // R4

    AST_RE_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |->
        re_ovf == ((SW'($past(op_re_a, 2)) * SW'($past(op_re_b, 2)))
                >= (SW'($past(op_im_a, 2)) * SW'($past(op_im_b, 2))))); // R5

endmodule

// File: tb/cplx_mul4_reg_tb_top.sv
`timescale 1ns/1ps
module cplx_mul4_reg_tb_top;

    localparam int NV    = 400;
    localparam int LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a = '0, b = '0, c = '0, d = '0;
    logic [7:0] re_out, im_out;
    logic       re_ovf, im_ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [3:0] va [NV];
    logic [3:0] vb [NV];
    logic [3:0] vc [NV];
    logic [3:0] vd [NV];

    always #4 clk = ~clk;

    cplx_mul4_reg dut_i (
        .clk (clk), .rst (rst),
        .op_re_a (a), .op_im_a (b), .op_re_b (c), .op_im_b (d),
        .re_out (re_out), .im_out (im_out),
        .re_ovf (re_ovf), .im_ovf (im_ovf)
    );

    function automatic int exp_re(int x, int y, int z, int w);
        return ((x * z - y * w) % 256 + 256) % 256;
    endfunction

    function automatic int exp_im(int x, int y, int z, int w);
        return (x * w + y * z) % 256;
    endfunction

    function automatic int exp_im_ovf(int x, int y, int z, int w);
        return (x * w + y * z > 255) ? 1 : 0;
    endfunction

    function automatic int exp_re_ovf(int x, int y, int z, int w);
        return (x * z >= y * w) ? 1 : 0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_vec(int k);
        int x = va[k];
        int y = vb[k];
        int z = vc[k];
        int w = vd[k];
        check("R2 re_out (R1 latency)", int'(re_out), exp_re(x, y, z, w));
        check("R3 im_out (R1 latency)", int'(im_out), exp_im(x, y, z, w));
        check("R4 im_ovf", int'(im_ovf), exp_im_ovf(x, y, z, w));
        check("R5 re_ovf", int'(re_ovf), exp_re_ovf(x, y, z, w));
    endtask

    task automatic set_vec(int k, int x, int y, int z, int w);
        va[k] = 4'(x);
        vb[k] = 4'(y);
        vc[k] = 4'(z);
        vd[k] = 4'(w);
    endtask

    task automatic check_zero(string req);
        check(req, int'(re_out), 0);
        check(req, int'(im_out), 0);
        check(req, int'(re_ovf), 0);
        check(req, int'(im_ovf), 0);
    endtask

    // Watchdog.
    initial begin
        int cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1f2e3d4c;
        void'($urandom(seed));
        // Directed corners.
        set_vec(0, 0, 0, 0, 0);       // all zero: re_ovf=1 (R5)
        set_vec(1, 15, 15, 15, 15);   // all ones: im 450 -> 194, flags 1
        set_vec(2, 15, 15, 0, 15);    // ac<bd: re 31, re_ovf 0
        set_vec(3, 15, 5, 6, 15);     // im exactly 255, no flag (R4)
        set_vec(4, 12, 8, 14, 12);    // im exactly 256 -> 0, flag (R4)
        set_vec(5, 15, 6, 6, 15);     // im 261 -> 5
        set_vec(6, 7, 3, 3, 7);       // ac==bd -> re 0, re_ovf 1
        for (int k = 7; k < NV; k++) begin
            set_vec(k, int'($urandom_range(15)), int'($urandom_range(15)),
                       int'($urandom_range(15)), int'($urandom_range(15)));
        end

        // Reset state (R6).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_zero("R6 reset");

        // Back-to-back stream (R1).
        for (int k = 0; k < NV + 2; k++) begin
            if (k == 0) rst = 1'b0;
            if (k >= 2) check_vec(k - 2);
            if (k < NV) begin
                a = va[k]; b = vb[k]; c = vc[k]; d = vd[k];
            end
            @(negedge clk);
        end

        // Reset mid-stream with nonzero operands clears outputs (R6).
        a = 4'd15; b = 4'd3; c = 4'd15; d = 4'd2;
        rst = 1'b1;
        @(negedge clk);
        check_zero("R6 reset held");
        @(negedge clk);
        check_zero("R6 reset held");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule